// File: doc/BRIEF.md
# PWM-Locked Third-Order Decimation Filter

This block turns the single-bit output of an external oversampling (sigma-delta) modulator into signed multi-bit current samples. It produces the modulator's clock by dividing the system clock. The divide ratio comes from the PWM period (in system clocks), the decimation factor and a chosen output-rate multiple. As a result the modulator runs at exactly the decimation factor times the output rate, and the output rate is a power-of-two multiple of the PWM switching frequency. The PWM ripple harmonics then fold onto DC, so no analog anti-alias filter is needed.

The filter is a sinc-cubed decimator. Three accumulators update on every modulator tick. Three differencing stages update once per frame of `DECIM` ticks. The sync pulse of a center-aligned PWM counter marks the zero-mean point of the current ripple, and it must fall on the last system cycle of a frame. When it does, the frame closes there normally. When it arrives anywhere else, the divider and the frame counter restart from that pulse, and the following output samples are held back until the differencing stages contain clean data again.

Raising the output-rate multiple reduces the filter's group delay by the same factor, but more ripple harmonics then fall in the passband. Removing them is left to downstream software.

Top module: `pwm_sync_decimator`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `mod_clk` and `sample_valid` are 0 and `sample` is 0.
- R2: With M = 2^`os_sel`, the divide ratio is `pwm_period` / (`DECIM`·M). `cfg_err` is 1 (combinationally) when that division leaves a remainder or the ratio is below 2. While `cfg_err` is 1, `mod_clk` stays 0 and no sample is produced.
- R3: `mod_clk` has a period of exactly ratio system cycles. It is high for the first floor(ratio/2) cycles of each period and rises in the cycle after a modulator tick. `mod_bit` is sampled in the last system cycle of each period.
- R4: A sampled `mod_bit` of 1 counts as +1 and a 0 counts as −1. A steady stream of 1s gives `sample` = +`DECIM`³, and a steady stream of 0s gives −`DECIM`³ (two's complement).
- R5: A valid `sample` equals the sum, over the most recent 3·`DECIM`−2 ticks, of each ±1 value times w(j). Here j = 0 is the newest tick, and w(j) is the number of triples (a,b,c) with each term in 0..`DECIM`−1 and a+b+c = j.
- R6: A frame is `DECIM` ticks long and closes on its last tick. With multiple M and a sync every ratio·`DECIM`·M cycles, exactly M samples are produced per sync interval.
- R7: A sync pulse that falls on the closing cycle of a frame gives a `sample_valid` pulse in the very next cycle.
- R8: A sync pulse on any other cycle produces no sample. It restarts the divider and the frame counter, so the cycle after the pulse is the first cycle of a new modulator period. The next three frame closes are not flagged valid, and the fourth one is.
- R9: After reset the first three frame closes are not flagged valid, and the fourth one is.
- R10: `sample_valid` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator bitstream |
| pwm_sync | input | 1 | Center-aligned PWM sync pulse |
| pwm_period | input | PER_W (16) | PWM period in system clock cycles |
| os_sel | input | OS_W (2) | Log2 of the output-rate multiple M |
| mod_clk | output | 1 | Clock driven to the modulator |
| sample | output | 3·log2(DECIM)+2 (20) | Signed decimated sample |
| sample_valid | output | 1 | One-cycle strobe qualifying `sample` |
| cfg_err | output | 1 | Configuration gives a non-integer or too-small ratio |

## Verification
Two events can land on the same system cycle: the natural close of a frame, and an incoming sync pulse. In the aligned case they coincide and a normal sample must appear. The bench also moves a single sync pulse one cycle early, and separately into the middle of a frame. After each move it expects no sample for that frame, three held-back closes, and then a valid sample four frame periods later. A behavioural model checks the strobe, the modulator clock and every valid sample on every cycle around these collisions, and counters confirm the blanking windows at the ports.

// File: rtl/pwmdec_pkg.sv
package pwmdec_pkg;

    localparam int CIC_ORDER = 3;

    // events produced by the time base for one system cycle
    typedef struct packed {
        logic tick;     // modulator period ends, bit is integrated
        logic close;    // tick that completes a frame
        logic resync;   // sync pulse away from a frame close
    } frame_evt_t;

    // comb settling progress after reset or resync
    typedef enum logic [1:0] {
        SETTLE_0,
        SETTLE_1,
        SETTLE_2,
        SETTLE_DONE
    } settle_t;

    // accumulator width: three stages of log2(D) growth plus sign and full-scale headroom
    function automatic int acc_bits(input int log_d);
        return CIC_ORDER * log_d + 2;
    endfunction

endpackage

// File: rtl/pwmdec_cfg.sv
module pwmdec_cfg #(
    parameter int PER_W = 16,
    parameter int OS_W  = 2,
    parameter int LOG_D = 6
) (
    input  logic [PER_W-1:0] period_i,
    input  logic [OS_W-1:0]  os_i,
    output logic [PER_W-1:0] ratio_o,
    output logic             err_o
);
    logic [PER_W-1:0] rem_mask;
    int               shamt;

    always_comb begin
        shamt    = LOG_D + int'(os_i);
        ratio_o  = period_i >> shamt;
        rem_mask = (PER_W'(1) << shamt) - PER_W'(1);
        err_o    = ((period_i & rem_mask) != '0) || (ratio_o < PER_W'(2));
    end

endmodule

// File: rtl/pwmdec_timebase.sv
module pwmdec_timebase
    import pwmdec_pkg::*;
#(
    parameter int DECIM = 64,
    parameter int PER_W = 16,
    localparam int LOG_D = $clog2(DECIM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic [PER_W-1:0] ratio_i,
    input  logic             err_i,
    output logic             mod_clk_o,
    output frame_evt_t       evt_o
);
    localparam logic [LOG_D-1:0] FRM_LAST = LOG_D'(DECIM - 1);

    logic [PER_W-1:0] div_q, div_d;
    logic [LOG_D-1:0] frm_q, frm_d;
    logic             at_edge, full, mod_next;

    always_comb begin
        at_edge      = !err_i && (div_q == ratio_i - PER_W'(1));
        full         = at_edge && (frm_q == FRM_LAST);
        evt_o.resync = !err_i && sync_i && !full;
        evt_o.tick   = at_edge && !evt_o.resync;
        evt_o.close  = full;

        div_d = div_q + PER_W'(1);
        frm_d = frm_q;
        if (err_i || evt_o.resync) begin
            div_d = '0;
            frm_d = '0;
        end else if (evt_o.tick) begin
            div_d = '0;
            frm_d = frm_q + LOG_D'(1);
        end
        mod_next = !err_i && (div_d < (ratio_i >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= '0;
            frm_q     <= '0;
            mod_clk_o <= 1'b0;
        end else begin
            div_q     <= div_d;
            frm_q     <= frm_d;
            mod_clk_o <= mod_next;
        end
    end

    // a closed frame starts the next one from zero (R6)
    assert_close_restart_R6: assert property (@(posedge clk) disable iff (rst)
        evt_o.close |=> (frm_q == '0 && div_q == '0));

    // any sync pulse leaves the counters at the start of a period (R8)
    assert_sync_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (sync_i && !err_i) |=> (frm_q == '0 && div_q == '0));

    // a bad configuration keeps the modulator clock parked low (R2)
    assert_cfg_park_R2: assert property (@(posedge clk) disable iff (rst)
        err_i |=> !mod_clk_o);

    // the modulator clock is high in the cycle after every tick (R3)
    assert_tick_rise_R3: assert property (@(posedge clk) disable iff (rst)
        evt_o.tick |=> mod_clk_o);

endmodule

// File: rtl/pwmdec_integ.sv
module pwmdec_integ
    import pwmdec_pkg::*;
#(
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [ACC_W-1:0] sum_o
);
    logic [ACC_W-1:0] step;

    // bit 1 counts +1, bit 0 counts -1 (modular arithmetic)
    assign step = bit_i ? ACC_W'(1) : '1;

    for (genvar k = 0; k < CIC_ORDER; k++) begin : g_int
        logic [ACC_W-1:0] stg_in;
        logic [ACC_W-1:0] acc_q;
        logic [ACC_W-1:0] acc_d;

        if (k == 0) begin : g_head
            assign stg_in = step;
        end else begin : g_chain
            assign stg_in = g_int[k-1].acc_d;
        end

        assign acc_d = acc_q + stg_in;

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
            end else if (en_i) begin
                acc_q <= acc_d;
            end
        end
    end

    assign sum_o = g_int[CIC_ORDER-1].acc_d;

endmodule

// File: rtl/pwmdec_comb.sv
module pwmdec_comb
    import pwmdec_pkg::*;
#(
    parameter int LOG_D = 6,
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close_i,
    input  logic             resync_i,
    input  logic             err_i,
    input  logic [ACC_W-1:0] in_i,
    output logic [ACC_W-1:0] sample_o,
    output logic             valid_o
);
    localparam logic signed [ACC_W-1:0] FULL_SCALE = ACC_W'(1) << (CIC_ORDER * LOG_D);

    settle_t settle_q;

    for (genvar k = 0; k < CIC_ORDER; k++) begin : g_comb
        logic [ACC_W-1:0] stg_in;
        logic [ACC_W-1:0] dly_q;
        logic [ACC_W-1:0] dif;

        if (k == 0) begin : g_head
            assign stg_in = in_i;
        end else begin : g_chain
            assign stg_in = g_comb[k-1].dif;
        end

        assign dif = stg_in - dly_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                dly_q <= '0;
            end else if (close_i) begin
                dly_q <= stg_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
            settle_q <= SETTLE_0;
        end else begin
            valid_o <= 1'b0;
            if (resync_i || err_i) begin
                settle_q <= SETTLE_0;
            end else if (close_i) begin
                sample_o <= g_comb[CIC_ORDER-1].dif;
                valid_o  <= (settle_q == SETTLE_DONE);
                if (settle_q != SETTLE_DONE) begin
                    settle_q <= settle_t'(settle_q + 2'd1);
                end
            end
        end
    end

    // strobe is a single cycle wide (R10)
    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // a valid sample only follows a frame close from the time base (R7)
    assert_valid_from_close_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(close_i));

    // valid samples stay within the filter's full scale (R4)
    assert_full_scale_R4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($signed(sample_o) <= FULL_SCALE && $signed(sample_o) >= -FULL_SCALE));

    // a resync never yields a sample in the following cycle (R8)
    assert_resync_blank_R8: assert property (@(posedge clk) disable iff (rst)
        resync_i |=> !valid_o);

endmodule

// File: rtl/pwm_sync_decimator.sv
module pwm_sync_decimator
    import pwmdec_pkg::*;
#(
    parameter int DECIM = 64,
    parameter int PER_W = 16,
    parameter int OS_W  = 2,
    localparam int LOG_D = $clog2(DECIM),
    localparam int ACC_W = acc_bits(LOG_D)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_bit,
    input  logic             pwm_sync,
    input  logic [PER_W-1:0] pwm_period,
    input  logic [OS_W-1:0]  os_sel,
    output logic             mod_clk,
    output logic [ACC_W-1:0] sample,
    output logic             sample_valid,
    output logic             cfg_err
);
    logic [PER_W-1:0] ratio;
    frame_evt_t       evt;
    logic [ACC_W-1:0] integ_sum;

    pwmdec_cfg #(
        .PER_W (PER_W),
        .OS_W  (OS_W),
        .LOG_D (LOG_D)
    ) u_cfg (
        .period_i (pwm_period),
        .os_i     (os_sel),
        .ratio_o  (ratio),
        .err_o    (cfg_err)
    );

    pwmdec_timebase #(
        .DECIM (DECIM),
        .PER_W (PER_W)
    ) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .sync_i    (pwm_sync),
        .ratio_i   (ratio),
        .err_i     (cfg_err),
        .mod_clk_o (mod_clk),
        .evt_o     (evt)
    );

    pwmdec_integ #(
        .ACC_W (ACC_W)
    ) u_integ (
        .clk   (clk),
        .rst   (rst),
        .en_i  (evt.tick),
        .bit_i (mod_bit),
        .sum_o (integ_sum)
    );

    pwmdec_comb #(
        .LOG_D (LOG_D),
        .ACC_W (ACC_W)
    ) u_comb (
        .clk      (clk),
        .rst      (rst),
        .close_i  (evt.close),
        .resync_i (evt.resync),
        .err_i    (cfg_err),
        .in_i     (integ_sum),
        .sample_o (sample),
        .valid_o  (sample_valid)
    );

endmodule

// File: tb/test_pwm_sync_decimator.sv
module test_pwm_sync_decimator;

    localparam int DECIM = 64;
    localparam int LOG_D = 6;
    localparam int ACC_W = 3 * LOG_D + 2;
    localparam int FS    = DECIM * DECIM * DECIM;
    localparam int WLEN  = 3 * DECIM;

    logic             clk = 1'b0;
    logic             rst;
    logic             mod_bit;
    logic             pwm_sync;
    logic [15:0]      pwm_period;
    logic [1:0]       os_sel;
    logic             mod_clk;
    logic [ACC_W-1:0] sample;
    logic             sample_valid;
    logic             cfg_err;

    always #2 clk = ~clk;

    pwm_sync_decimator i_pwm_sync_decimator (
        .clk          (clk),
        .rst          (rst),
        .mod_bit      (mod_bit),
        .pwm_sync     (pwm_sync),
        .pwm_period   (pwm_period),
        .os_sel       (os_sel),
        .mod_clk      (mod_clk),
        .sample       (sample),
        .sample_valid (sample_valid),
        .cfg_err      (cfg_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int     wt [WLEN];
    int     hist[$];
    int     m_div, m_frm, m_sc;
    bit     m_mclk, m_valid;
    longint m_sample;

    function automatic int calc_ratio(input logic [15:0] per, input logic [1:0] os);
        return int'(per) >> (LOG_D + int'(os));
    endfunction

    function automatic bit calc_err(input logic [15:0] per, input logic [1:0] os);
        int sh = LOG_D + int'(os);
        return ((int'(per) % (1 << sh)) != 0) || (calc_ratio(per, os) < 2);
    endfunction

    function automatic longint wsum();
        longint s = 0;
        for (int j = 0; j < hist.size() && j < WLEN; j++) s += longint'(wt[j]) * hist[j];
        return s;
    endfunction

    initial begin
        int box2 [2*DECIM];
        for (int k = 0; k < 2 * DECIM; k++) box2[k] = 0;
        for (int a = 0; a < DECIM; a++)
            for (int b = 0; b < DECIM; b++) box2[a+b]++;
        for (int j = 0; j < WLEN; j++) begin
            wt[j] = 0;
            for (int c = 0; c < DECIM; c++)
                if (j - c >= 0 && j - c < 2 * DECIM - 1) wt[j] += box2[j-c];
        end
    end

    always @(posedge clk) begin
        int  ratio;
        bit  err, edge_now, full;
        ratio = calc_ratio(pwm_period, os_sel);
        err   = calc_err(pwm_period, os_sel);
        if (rst) begin
            m_div = 0; m_frm = 0; m_sc = 0; m_mclk = 0; m_valid = 0; m_sample = 0;
            hist.delete();
        end else if (err) begin
            m_div = 0; m_frm = 0; m_sc = 0; m_mclk = 0; m_valid = 0;
        end else begin
            edge_now = (m_div == ratio - 1);
            full     = edge_now && (m_frm == DECIM - 1);
            m_valid  = 0;
            if (pwm_sync && !full) begin
                m_div = 0; m_frm = 0; m_sc = 0;
            end else if (edge_now) begin
                hist.push_front(mod_bit ? 1 : -1);
                if (hist.size() > WLEN) void'(hist.pop_back());
                m_div = 0;
                m_frm = (m_frm + 1) % DECIM;
                if (full) begin
                    if (m_sc == 3) begin
                        m_valid  = 1;
                        m_sample = wsum();
                    end else begin
                        m_sc++;
                    end
                end
            end else begin
                m_div++;
            end
            m_mclk = (m_div < ratio / 2);
        end
    end

    // ---------------- stimulus and per-cycle comparison ----------------
    int         sync_per;
    int         pcnt;
    int         mode;
    int         gcnt = 0;
    logic [15:0] lfsr = 16'hACE1;
    int         n_valid = 0;
    int         n_valid_sync = 0;
    int         n_rise = 0;
    int         run_len = 0;
    int         max_run = 0;
    bit         prev_mclk = 0;
    longint     last_sample = 0;

    task automatic cycle();
        @(negedge clk);
        chk("R2", "cfg_err", longint'(cfg_err), longint'(calc_err(pwm_period, os_sel)));
        if (!rst) begin
            chk("R3", "mod_clk", longint'(mod_clk), longint'(m_mclk));
            chk("R7/R8/R9", "sample_valid", longint'(sample_valid), longint'(m_valid));
            if (m_valid)
                chk("R5", "sample", longint'($signed(sample)), m_sample);
        end
        if (sample_valid) begin
            n_valid++;
            last_sample = longint'($signed(sample));
            if (pwm_sync) n_valid_sync++;
            run_len++;
        end else begin
            run_len = 0;
        end
        if (run_len > max_run) max_run = run_len;
        if (mod_clk && !prev_mclk) n_rise++;
        prev_mclk = mod_clk;
        // drive next cycle
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        gcnt++;
        case (mode)
            0:       mod_bit = 1'b1;
            1:       mod_bit = 1'b0;
            2:       mod_bit = lfsr[0];
            default: mod_bit = ((gcnt % 7) < 5);
        endcase
        pwm_sync = 1'b0;
        if (!rst) begin
            pwm_sync = (pcnt == sync_per - 1);
            pcnt     = (pcnt + 1) % sync_per;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic restart(input logic [15:0] per, input logic [1:0] os, input int sper);
        rst        = 1'b1;
        pwm_period = per;
        os_sel     = os;
        sync_per   = sper;
        pcnt       = 0;
        run(4);
        rst  = 1'b0;
        pcnt = 1;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected < 150000", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v0;
        rst = 1'b1; mod_bit = 1'b0; pwm_sync = 1'b0;
        pwm_period = 16'd256; os_sel = 2'd0; sync_per = 256; pcnt = 0; mode = 0;
        run(3);
        // R1: reset state
        chk("R1", "mod_clk in reset", longint'(mod_clk), 0);
        chk("R1", "sample_valid in reset", longint'(sample_valid), 0);
        chk("R1", "sample in reset", longint'(sample), 0);

        // R9: after reset only the fourth close is valid
        restart(16'd256, 2'd0, 256);
        v0 = n_valid;
        run(4 * 256 - 1);
        chk("R9", "valids before fourth close", n_valid - v0, 0);
        run(1);
        chk("R9", "valid at fourth close", n_valid - v0, 1);

        // R4: all ones gives positive full scale
        run(2 * 256);
        chk("R4", "all-ones sample", last_sample, FS);

        // R4: all zeros gives negative full scale
        mode = 1;
        run(5 * 256);
        chk("R4", "all-zeros sample", last_sample, -FS);

        // R5 / R7: random bitstream, every sample right after the sync
        mode = 2;
        run(3 * 256);
        v0 = n_valid_sync;
        run(4 * 256);
        chk("R7", "samples right after sync", n_valid_sync - v0, 4);
        mode = 3;
        run(4 * 256);

        // R8: sync one cycle early aborts the frame
        mode = 2;
        while (pcnt != sync_per - 2) cycle();
        pcnt = sync_per - 1;
        run(1);
        v0 = n_valid;
        run(4 * 256);
        chk("R8", "valids after early sync", n_valid - v0, 0);
        run(1);
        chk("R8", "valid at fourth close after early sync", n_valid - v0, 1);

        // R8: sync in the middle of a frame
        while (pcnt != 100) cycle();
        pcnt = sync_per - 1;
        run(1);
        v0 = n_valid;
        run(4 * 256);
        chk("R8", "valids after mid-frame sync", n_valid - v0, 0);
        run(1);
        chk("R8", "valid at fourth close after mid-frame sync", n_valid - v0, 1);
        run(2 * 256);

        // R6: multiple 2 gives two samples per sync interval
        restart(16'd512, 2'd1, 512);
        run(3 * 512);
        v0 = n_valid;
        run(2 * 512);
        chk("R6", "samples per two sync periods at M=2", n_valid - v0, 4);

        // R3: smallest ratio of 2
        restart(16'd128, 2'd0, 128);
        run(10);
        v0 = n_rise;
        run(128);
        chk("R3", "mod_clk rises in 128 cycles at ratio 2", n_rise - v0, 64);
        run(6 * 128);

        // R2: non-integer ratio
        restart(16'd250, 2'd0, 250);
        v0 = n_rise + n_valid;
        run(600);
        chk("R2", "cfg_err for period 250", longint'(cfg_err), 1);
        chk("R2", "no activity under config error", n_rise + n_valid - v0, 0);

        // R2: ratio below two
        restart(16'd512, 2'd3, 512);
        run(20);
        chk("R2", "cfg_err for ratio 1", longint'(cfg_err), 1);
        restart(16'd512, 2'd2, 512);
        run(20);
        chk("R2", "cfg_err clear for ratio 2 at M=4", longint'(cfg_err), 0);
        run(6 * 128);

        // R10: strobe never longer than one cycle
        chk("R10", "longest strobe run", max_run, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule